// File: doc/BRIEF.md
# Predicate Register File with Commit Gating

This block holds a bank of one-bit predicates that compare operations fill in and that later instructions consult before they commit. A compare updates two predicates in one cycle. Port A takes the compare outcome and port B takes its complement. Each port has its own enable and target index. The stored predicates are visible to any consumer, and a registered write becomes visible in the cycle after the clock edge that captures it.

A single qualifying-predicate read port selects one entry. It combines that entry with an instruction-valid input to form a commit enable, and an instruction whose predicate is false acts as a no-op. Entry 0 is a constant true, so selecting it expresses an unconditional instruction. Writes aimed at entry 0 are dropped without any fault.

For context switches, the whole file can be read as one packed word and loaded from one packed word in a single cycle. In that word, bit i is predicate i.

Top module: `pred_file`

## Requirements
- R1: After reset is asserted, predicates 1 to 63 read false and `save_word_o` equals 64'h1.
- R2: Predicate 0 always reads true. A port A write, a port B write or a restore bit 0 of value 0 aimed at it leaves it true and raises no fault.
- R3: When `cmp_we_a_i` is high (and no restore is requested), the predicate at `cmp_idx_a_i` takes `cmp_res_i` from the next cycle on.
- R4: When `cmp_we_b_i` is high (and no restore is requested), the predicate at `cmp_idx_b_i` takes the inverse of `cmp_res_i` from the next cycle on.
- R5: When both compare ports are enabled on the same index, that predicate takes the port A value (`cmp_res_i`).
- R6: When `restore_i` is high, predicate i for i in 1..63 takes `restore_word_i[i]` from the next cycle on. Predicate 0 stays true.
- R7: A restore in the same cycle as compare writes overrides them, so the result equals a restore alone.
- R8: `save_word_o[i]` equals predicate i for every i, and updates in the same cycle as the stored state.
- R9: `qp_val_o` equals the predicate selected by `qp_idx_i`, and `commit_o` equals `insn_valid_i & qp_val_o`. Both are combinational. With `qp_idx_i` = 0, `commit_o` follows `insn_valid_i`.
- R10: A predicate not targeted by an enabled write or a restore keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_we_a_i | input | 1 | Enable for port A (true outcome) |
| cmp_idx_a_i | input | 6 | Target index for port A |
| cmp_we_b_i | input | 1 | Enable for port B (complement outcome) |
| cmp_idx_b_i | input | 6 | Target index for port B |
| cmp_res_i | input | 1 | Compare outcome |
| restore_i | input | 1 | Load all predicates from the packed word |
| restore_word_i | input | 64 | Packed restore value, bit i is predicate i |
| save_word_o | output | 64 | Packed current predicates, bit i is predicate i |
| insn_valid_i | input | 1 | An instruction wants to commit this cycle |
| qp_idx_i | input | 6 | Qualifying predicate index |
| qp_val_o | output | 1 | Value of the selected predicate |
| commit_o | output | 1 | Commit enable for the instruction |

## Verification
The assertions run on every cycle and cover the following:
- each port write lands one cycle later with the right polarity;
- a restore replaces the upper 63 bits;
- idle cycles leave the packed word stable;
- a commit never occurs without a valid instruction and a true predicate;
- qualifying with entry 0 passes the valid input straight through.

Some behaviour only the bench scenarios can show:
- that entry 0 stays true after targeted writes and restores;
- that port A wins a same-index collision;
- that a restore overrides compare writes in the same cycle.

The bench shows these with index sweeps, collision cases and a long seeded random run against an arithmetic model.

// File: rtl/pred_pkg.sv
package pred_pkg;
  localparam int unsigned PRED_N = 64;

  // per-entry next-state source
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_CMP_A = 2'd1,
    SRC_CMP_B = 2'd2,
    SRC_BULK = 2'd3
  } wr_src_e;
endpackage

// File: rtl/pred_wr_arb.sv
module pred_wr_arb
  import pred_pkg::*;
#(
  parameter int unsigned NUM_PRED = PRED_N,
  localparam int unsigned IDX_W = $clog2(NUM_PRED)
) (
  input  logic             restore_i,
  input  logic             we_a_i,
  input  logic [IDX_W-1:0] idx_a_i,
  input  logic             we_b_i,
  input  logic [IDX_W-1:0] idx_b_i,
  output wr_src_e          src_o [NUM_PRED]
);
  // entry 0 never changes
  assign src_o[0] = SRC_HOLD;

  for (genvar i = 1; i < NUM_PRED; i++) begin : g_sel
    logic hit_a, hit_b;
    assign hit_a = we_a_i && (idx_a_i == IDX_W'(i));
    assign hit_b = we_b_i && (idx_b_i == IDX_W'(i));
    // restore > port A > port B
    always_comb begin
      if (restore_i)  src_o[i] = SRC_BULK;
      else if (hit_a) src_o[i] = SRC_CMP_A;
      else if (hit_b) src_o[i] = SRC_CMP_B;
      else            src_o[i] = SRC_HOLD;
    end
  end
endmodule

// File: rtl/pred_store.sv
module pred_store
  import pred_pkg::*;
#(
  parameter int unsigned NUM_PRED = PRED_N
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  wr_src_e             src_i [NUM_PRED],
  input  logic                cmp_res_i,
  input  logic [NUM_PRED-1:0] bulk_i,
  output logic [NUM_PRED-1:0] bits_o
);
  // hardwired true entry, no storage
  assign bits_o[0] = 1'b1;

  for (genvar i = 1; i < NUM_PRED; i++) begin : g_ent
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else begin
        unique case (src_i[i])
          SRC_CMP_A: q <= cmp_res_i;
          SRC_CMP_B: q <= ~cmp_res_i;
          SRC_BULK:  q <= bulk_i[i];
          default:   q <= q;
        endcase
      end
    end
    assign bits_o[i] = q;
  end
endmodule

// File: rtl/pred_gate.sv
module pred_gate #(
  parameter int unsigned NUM_PRED = pred_pkg::PRED_N,
  localparam int unsigned IDX_W = $clog2(NUM_PRED)
) (
  input  logic [NUM_PRED-1:0] bits_i,
  input  logic                valid_i,
  input  logic [IDX_W-1:0]    qp_idx_i,
  output logic                qp_val_o,
  output logic                commit_o
);
  assign qp_val_o = bits_i[qp_idx_i];
  assign commit_o = valid_i & qp_val_o;
endmodule

// File: rtl/pred_file.sv
module pred_file
  import pred_pkg::*;
#(
  parameter int unsigned NUM_PRED = PRED_N,
  localparam int unsigned IDX_W = $clog2(NUM_PRED)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmp_we_a_i,
  input  logic [IDX_W-1:0]    cmp_idx_a_i,
  input  logic                cmp_we_b_i,
  input  logic [IDX_W-1:0]    cmp_idx_b_i,
  input  logic                cmp_res_i,
  input  logic                restore_i,
  input  logic [NUM_PRED-1:0] restore_word_i,
  output logic [NUM_PRED-1:0] save_word_o,
  input  logic                insn_valid_i,
  input  logic [IDX_W-1:0]    qp_idx_i,
  output logic                qp_val_o,
  output logic                commit_o
);
  wr_src_e             src [NUM_PRED];
  logic [NUM_PRED-1:0] bits;

  pred_wr_arb #(.NUM_PRED(NUM_PRED)) u_arb (
    .restore_i (restore_i),
    .we_a_i    (cmp_we_a_i),
    .idx_a_i   (cmp_idx_a_i),
    .we_b_i    (cmp_we_b_i),
    .idx_b_i   (cmp_idx_b_i),
    .src_o     (src)
  );

  pred_store #(.NUM_PRED(NUM_PRED)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_i     (src),
    .cmp_res_i (cmp_res_i),
    .bulk_i    (restore_word_i),
    .bits_o    (bits)
  );

  pred_gate #(.NUM_PRED(NUM_PRED)) u_gate (
    .bits_i   (bits),
    .valid_i  (insn_valid_i),
    .qp_idx_i (qp_idx_i),
    .qp_val_o (qp_val_o),
    .commit_o (commit_o)
  );

  assign save_word_o = bits;
endmodule

// File: rtl/pred_file_chk.sv
module pred_file_chk #(
  parameter int unsigned NUM_PRED = pred_pkg::PRED_N,
  localparam int unsigned IDX_W = $clog2(NUM_PRED)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cmp_we_a_i,
  input logic [IDX_W-1:0]    cmp_idx_a_i,
  input logic                cmp_we_b_i,
  input logic [IDX_W-1:0]    cmp_idx_b_i,
  input logic                cmp_res_i,
  input logic                restore_i,
  input logic [NUM_PRED-1:0] restore_word_i,
  input logic [NUM_PRED-1:0] save_word_o,
  input logic                insn_valid_i,
  input logic [IDX_W-1:0]    qp_idx_i,
  input logic                qp_val_o,
  input logic                commit_o
);
  a_r3_port_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_we_a_i && !restore_i && cmp_idx_a_i != '0)
    |=> save_word_o[$past(cmp_idx_a_i)] == $past(cmp_res_i));

  a_r4_port_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_we_b_i && !restore_i && cmp_idx_b_i != '0 &&
     !(cmp_we_a_i && cmp_idx_a_i == cmp_idx_b_i))
    |=> save_word_o[$past(cmp_idx_b_i)] == !$past(cmp_res_i));

  a_r6_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> save_word_o[NUM_PRED-1:1] == $past(restore_word_i[NUM_PRED-1:1]));

  a_r10_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restore_i && !cmp_we_a_i && !cmp_we_b_i) |=> $stable(save_word_o));

  a_r9_commit_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (insn_valid_i && qp_val_o));

  a_r9_uncond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qp_idx_i == '0) |-> (commit_o == insn_valid_i));
endmodule

bind pred_file pred_file_chk #(.NUM_PRED(NUM_PRED)) u_chk (.*);

// File: tb/pred_file_test.sv
module pred_file_test;
  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we_a = 0, we_b = 0, res = 0, rst_req = 0, valid = 0;
  logic [5:0]    ia = 0, ib = 0, qp = 0;
  logic [N-1:0]  rword = '0, save;
  logic          qpv, commit;
  logic [N-1:0]  model;
  int            n_chk = 0, n_bad = 0;
  bit            done = 0;

  always #2 clk = ~clk;  // 250 MHz

  pred_file uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmp_we_a_i(we_a), .cmp_idx_a_i(ia),
    .cmp_we_b_i(we_b), .cmp_idx_b_i(ib),
    .cmp_res_i(res), .restore_i(rst_req), .restore_word_i(rword),
    .save_word_o(save), .insn_valid_i(valid), .qp_idx_i(qp),
    .qp_val_o(qpv), .commit_o(commit)
  );

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] next_model(input logic [N-1:0] cur);
    logic [N-1:0] nx = cur;
    if (rst_req) nx = {rword[N-1:1], 1'b1};
    else begin
      if (we_b && ib != 0) nx[ib] = ~res;
      if (we_a && ia != 0) nx[ia] = res;  // A applied last wins
    end
    return nx;
  endfunction

  // inputs set after negedge; apply one edge, return at next negedge
  task automatic cyc();
    logic [N-1:0] nx = next_model(model);
    @(posedge clk);
    @(negedge clk);
    model = nx;
    we_a = 0; we_b = 0; rst_req = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model = 64'h1;
    repeat (3) @(negedge clk);
    chk(save == 64'h1, "R1 reset word", save, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(save == 64'h1, "R1 after release", save, 64'h1);

    // R3 sweep: port A sets each entry
    for (int i = 0; i < N; i++) begin
      we_a = 1; ia = 6'(i); res = 1; cyc();
      chk(save == model, $sformatf("R3 set idx %0d", i), save, model);
    end
    chk(save == {N{1'b1}}, "R3 all set", save, {N{1'b1}});
    // R4 sweep: port B clears each entry (res=1 -> writes 0), R2 idx0 stays
    for (int i = 0; i < N; i++) begin
      we_b = 1; ib = 6'(i); res = 1; cyc();
      chk(save == model, $sformatf("R4 clr idx %0d", i), save, model);
    end
    chk(save == 64'h1, "R2 R4 entry0 survives", save, 64'h1);

    // R2: port A writes 0 to entry 0
    we_a = 1; ia = 0; res = 0; cyc();
    chk(save[0] == 1'b1, "R2 port A idx0", save, model);

    // R5 collisions
    for (int i = 1; i < N; i += 7) begin
      for (int r = 0; r < 2; r++) begin
        we_a = 1; we_b = 1; ia = 6'(i); ib = 6'(i); res = r[0]; cyc();
        chk(save[i] == r[0] && save == model, $sformatf("R5 idx %0d res %0d", i, r), save, model);
      end
    end

    // R6 restore patterns incl bit0 = 0
    begin
      logic [N-1:0] pats [4] = '{64'hA5A5_5A5A_0F0F_F0F0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFE, 64'h8000_0000_0000_0002};
      for (int p = 0; p < 4; p++) begin
        rst_req = 1; rword = pats[p]; cyc();
        chk(save == {pats[p][N-1:1], 1'b1}, $sformatf("R6 R2 restore %0d", p), save, {pats[p][N-1:1], 1'b1});
      end
    end

    // R7 restore beats compare
    rst_req = 1; rword = 64'h0123_4567_89AB_CDEF; we_a = 1; ia = 6'd2; res = 1;
    we_b = 1; ib = 6'd5; cyc();
    chk(save == 64'h0123_4567_89AB_CDEF && save[2] == 1'b1 && save[5] == 1'b1,
        "R7 restore priority", save, 64'h0123_4567_89AB_CDEF);
    rst_req = 1; rword = 64'h0; we_a = 1; ia = 6'd9; res = 1; cyc();
    chk(save == 64'h1, "R7 restore zero over write", save, 64'h1);

    // R10 idle
    rst_req = 1; rword = 64'hDEAD_BEEF_CAFE_F00D; cyc();
    for (int k = 0; k < 4; k++) cyc();
    chk(save == model, "R10 idle hold", save, model);

    // R8 R9 full sweep of qualifying read
    for (int i = 0; i < N; i++) begin
      for (int v = 0; v < 2; v++) begin
        qp = 6'(i); valid = v[0]; #0.5;
        chk(qpv == model[i], $sformatf("R9 qp idx %0d", i), {63'b0, qpv}, {63'b0, model[i]});
        chk(commit == (v[0] & model[i]), $sformatf("R9 commit idx %0d v %0d", i, v),
            {63'b0, commit}, {63'b0, v[0] & model[i]});
      end
    end
    chk(save == model, "R8 packed view", save, model);

    // random mix, R3 R4 R5 R7 R10
    void'($urandom(32'd77));
    for (int k = 0; k < 3000; k++) begin
      we_a = 1'($urandom); we_b = 1'($urandom); ia = 6'($urandom); ib = 6'($urandom);
      if (k % 5 == 0) ib = ia;
      res = 1'($urandom); rst_req = ($urandom % 16) == 0;
      rword = {$urandom, $urandom};
      qp = 6'($urandom); valid = 1'($urandom);
      #0.5;
      chk(commit == (valid & model[qp]), "R9 random commit", {63'b0, commit}, {63'b0, valid & model[qp]});
      cyc();
      chk(save == model, "R10 random state", save, model);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule